// File: doc/BRIEF.md
# Paged Effective Address Generator

This block works out the final operand address for a memory-reference instruction on a 12-bit, word-addressed machine. Memory is divided into 128-word pages. The instruction's 7-bit offset is placed either in page zero or in the page that holds the instruction. When the instruction asks for it, the block follows one level of indirection: it reads a pointer word from the formed address, and that word becomes the operand address.

A small window of page-zero cells acts as self-advancing pointers. An indirect reference through one of them reads the cell and adds one. It writes the new value back and hands that new value on as the operand address. The block drives a simple synchronous memory port: address, read and write strobes, write data, and read data that returns one cycle after the read strobe.

The surrounding core pulses `start_i` with the instruction word and its fetch address, then waits for `done_o`. The block does not decode the opcode. It does not execute the instruction or touch the program counter.

Top module: `eaddr_gen`

## Requirements
- R1: Instruction fields are bits 11:9 opcode (ignored here), bit 8 indirect, bit 7 page select and bits 6:0 offset. With page select 0 the formed address is the offset with bits 11:7 zero.
- R2: With page select 1, bits 11:7 of the formed address equal bits 11:7 of `iaddr_i`, and bits 6:0 equal the offset.
- R3: With indirect clear, `done_o` is high in the same cycle as an accepted `start_i`, `ea_o` equals the formed address, and no read or write strobe is issued.
- R4: With indirect set, exactly one read is strobed at the formed address in the cycle after `start_i`. Outside the pointer window, `done_o` rises two cycles after `start_i` with `ea_o` equal to the word that was read.
- R5: An indirect reference whose formed address is octal 0010–0017 writes the read word plus one back to that address. The write happens three cycles after `start_i`, and `done_o` is high in that same cycle with `ea_o` equal to the written value.
- R6: The pointer increment wraps modulo 4096, so octal 7777 becomes 0000.
- R7: A direct reference to octal 0010–0017 leaves memory unchanged. An indirect reference outside that window, including offset 010 on a nonzero current page, issues no write.
- R8: `start_i` is ignored while a reference is in progress.
- R9: During and after reset, `done_o`, `mem_rd_o` and `mem_wr_o` are low, and a reference cut short by reset leaves no strobe active.
- R10: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin address generation for `instr_i` |
| instr_i | input | 12 | Memory-reference instruction word |
| iaddr_i | input | 12 | Address the instruction was fetched from |
| mem_addr_o | output | 12 | Memory port address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 12 | Memory write data |
| mem_rdata_i | input | 12 | Memory read data, valid one cycle after the read strobe |
| ea_o | output | 12 | Effective address, valid while `done_o` is high |
| done_o | output | 1 | Effective address ready |

## Verification
The assertions assume the memory presents the addressed word on `mem_rdata_i` in the cycle after the read strobe and holds it there until the next access. The write-back check relates the written word to that held value.

The stimulus memory model in the bench registers read data on the strobe and keeps it between accesses. It preloads the pointer words through its own port while the block is idle. `start_i` is raised for a single cycle for each reference, except in the deliberate busy-overlap test.

// File: rtl/eag_pkg.sv
`timescale 1ns/1ps
package eag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_RESP  = 2'd2,
    ST_WBACK = 2'd3
  } eag_state_e;
endpackage

// File: rtl/eag_form.sv
`timescale 1ns/1ps
module eag_form #(
  parameter int AW      = 12,
  parameter int OFFW    = 7,
  parameter int IW      = 12,
  parameter int AI_BASE = 8,
  parameter int AI_SPAN = 8
) (
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] iaddr,
  output logic [AW-1:0] formed,
  output logic          ind,
  output logic          ai_cell
);
  localparam int PW = AW - OFFW;
  localparam logic [OFFW:0] AI_LO = (OFFW+1)'(AI_BASE);
  localparam logic [OFFW:0] AI_HI = (OFFW+1)'(AI_BASE + AI_SPAN);

  logic            pg_sel;
  logic [OFFW-1:0] offs;
  logic            in_win;

  assign pg_sel = instr[OFFW];
  assign ind    = instr[OFFW+1];
  assign offs   = instr[OFFW-1:0];

  always_comb begin
    if (pg_sel) formed = {iaddr[AW-1:OFFW], offs};
    else        formed = {{PW{1'b0}}, offs};
  end

  assign in_win  = ({1'b0, offs} >= AI_LO) && ({1'b0, offs} < AI_HI);
  assign ai_cell = (formed[AW-1:OFFW] == '0) && in_win;
endmodule

// File: rtl/eag_ctrl.sv
`timescale 1ns/1ps
module eag_ctrl
  import eag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ind,
  input  logic       ai_q,
  output eag_state_e state,
  output logic       load,
  output logic       cap
);
  eag_state_e state_nx;
  logic       st_en;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (start && ind) state_nx = ST_READ;
      ST_READ:  state_nx = ST_RESP;
      ST_RESP:  state_nx = ai_q ? ST_WBACK : ST_IDLE;
      ST_WBACK: state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  assign st_en = (state_nx != state);
  assign load  = (state == ST_IDLE) && start && ind;
  assign cap   = (state == ST_RESP) && ai_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state <= ST_IDLE;
    else if (st_en) state <= state_nx;
  end
endmodule

// File: rtl/eag_dp.sv
`timescale 1ns/1ps
module eag_dp #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          cap,
  input  logic [AW-1:0] formed,
  input  logic          ai_in,
  input  logic [AW-1:0] rdata,
  output logic [AW-1:0] addr_q,
  output logic          ai_q,
  output logic [AW-1:0] inc_q
);
  logic [AW-1:0] inc_nx;

  assign inc_nx = rdata + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ai_q   <= 1'b0;
    end else if (load) begin
      addr_q <= formed;
      ai_q   <= ai_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   inc_q <= '0;
    else if (cap) inc_q <= inc_nx;
  end
endmodule

// File: rtl/eaddr_gen.sv
`timescale 1ns/1ps
module eaddr_gen
  import eag_pkg::*;
#(
  parameter int AW      = 12,
  parameter int OFFW    = 7,
  parameter int OPW     = 3,
  parameter int AI_BASE = 8,
  parameter int AI_SPAN = 8,
  localparam int IW     = OPW + 2 + OFFW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [IW-1:0] instr_i,
  input  logic [AW-1:0] iaddr_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic [AW-1:0] mem_rdata_i,
  output logic [AW-1:0] ea_o,
  output logic          done_o
);
  logic [AW-1:0] formed;
  logic          ind;
  logic          ai_cell;
  eag_state_e    state;
  logic          load;
  logic          cap;
  logic [AW-1:0] addr_q;
  logic          ai_q;
  logic [AW-1:0] inc_q;
  logic          busy;

  eag_form #(
    .AW(AW), .OFFW(OFFW), .IW(IW), .AI_BASE(AI_BASE), .AI_SPAN(AI_SPAN)
  ) u_form (
    .instr(instr_i), .iaddr(iaddr_i), .formed(formed), .ind(ind), .ai_cell(ai_cell)
  );

  eag_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .ind(ind), .ai_q(ai_q),
    .state(state), .load(load), .cap(cap)
  );

  eag_dp #(.AW(AW)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .cap(cap), .formed(formed),
    .ai_in(ai_cell), .rdata(mem_rdata_i), .addr_q(addr_q), .ai_q(ai_q), .inc_q(inc_q)
  );

  assign busy        = (state != ST_IDLE);
  assign mem_addr_o  = addr_q;
  assign mem_rd_o    = (state == ST_READ);
  assign mem_wr_o    = (state == ST_WBACK);
  assign mem_wdata_o = inc_q;

  always_comb begin
    ea_o   = '0;
    done_o = 1'b0;
    case (state)
      ST_IDLE: begin
        ea_o   = formed;
        done_o = start_i && !ind;
      end
      ST_RESP: begin
        ea_o   = mem_rdata_i;
        done_o = !ai_q;
      end
      ST_WBACK: begin
        ea_o   = inc_q;
        done_o = 1'b1;
      end
      default: begin
        ea_o   = '0;
        done_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/eaddr_gen_chk.sv
`timescale 1ns/1ps
module eaddr_gen_chk #(
  parameter int AW      = 12,
  parameter int OFFW    = 7,
  parameter int IW      = 12,
  parameter int AI_BASE = 8,
  parameter int AI_SPAN = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [IW-1:0] instr_i,
  input logic          busy,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [AW-1:0] mem_wdata_o,
  input logic [AW-1:0] mem_rdata_i,
  input logic [AW-1:0] ea_o,
  input logic          done_o
);
  localparam logic [AW-1:0] WIN_LO = AW'(AI_BASE);
  localparam logic [AW-1:0] WIN_HI = AW'(AI_BASE + AI_SPAN);

  AST_DIRECT_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && !instr_i[OFFW+1]) |->
      (done_o && !mem_rd_o && !mem_wr_o && ea_o[OFFW-1:0] == instr_i[OFFW-1:0])); // R3

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o); // R4

  AST_NO_DONE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> !done_o); // R4

  AST_WB_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (mem_wdata_o == $past(mem_rdata_i) + AW'(1) && ea_o == mem_wdata_o && done_o)); // R5

  AST_WB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (mem_addr_o >= WIN_LO && mem_addr_o < WIN_HI)); // R7

  AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> $past(mem_rd_o, 2)); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o)); // R10
endmodule

bind eaddr_gen eaddr_gen_chk #(
  .AW(AW), .OFFW(OFFW), .IW(IW), .AI_BASE(AI_BASE), .AI_SPAN(AI_SPAN)
) u_chk (.*);

// File: tb/eaddr_gen_tb.sv
`timescale 1ns/1ps
module eaddr_gen_tb;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [11:0] instr_i;
  logic [11:0] iaddr_i;
  logic [11:0] mem_addr_o;
  logic        mem_rd_o;
  logic        mem_wr_o;
  logic [11:0] mem_wdata_o;
  logic [11:0] mem_rdata_i;
  logic [11:0] ea_o;
  logic        done_o;

  int n_chk;
  int n_fail;

  // bench memory with a preload port
  logic [11:0] mem [4096];
  logic        pl_we;
  logic [11:0] pl_addr;
  logic [11:0] pl_data;

  eaddr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i), .iaddr_i(iaddr_i),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .ea_o(ea_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
    if (pl_we)    mem[pl_addr] <= pl_data;
  end

  // {op, ind, pg, off, iaddr, preset, expected cycles to done}
  localparam int NV = 10;
  localparam logic [37:0] VEC [NV] = '{
    {3'o1, 1'b0, 1'b0, 7'o045, 12'o3456, 12'o0000, 2'd0},
    {3'o2, 1'b0, 1'b1, 7'o123, 12'o5201, 12'o0000, 2'd0},
    {3'o3, 1'b0, 1'b0, 7'o012, 12'o1000, 12'o4444, 2'd0},
    {3'o0, 1'b1, 1'b0, 7'o050, 12'o0200, 12'o6543, 2'd2},
    {3'o4, 1'b1, 1'b1, 7'o177, 12'o7777, 12'o0012, 2'd2},
    {3'o1, 1'b1, 1'b0, 7'o010, 12'o2000, 12'o1233, 2'd3},
    {3'o5, 1'b1, 1'b0, 7'o017, 12'o4321, 12'o7777, 2'd3},
    {3'o2, 1'b1, 1'b0, 7'o007, 12'o0000, 12'o0100, 2'd2},
    {3'o3, 1'b1, 1'b0, 7'o020, 12'o0600, 12'o0300, 2'd2},
    {3'o0, 1'b1, 1'b1, 7'o010, 12'o0400, 12'o2222, 2'd2}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_formed(input logic pg, input logic [6:0] off, input logic [11:0] ia);
    return pg ? {ia[11:7], off} : {5'b0, off};
  endfunction

  function automatic logic ref_ai(input logic ind, input logic [11:0] fa);
    return ind && fa[11:7] == 5'b0 && fa[6:0] >= 7'o010 && fa[6:0] <= 7'o017;
  endfunction

  task automatic preload(input logic [11:0] a, input logic [11:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    pl_we = 1'b0; pl_addr = '0; pl_data = '0;
    start_i = 1'b0; instr_i = '0; iaddr_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    chk(!done_o && !mem_rd_o && !mem_wr_o, "R9 reset outputs", {done_o, mem_rd_o, mem_wr_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      logic [2:0]  op;
      logic        ind, pg;
      logic [6:0]  off;
      logic [11:0] ia, pre, fa, exp_ea, exp_mem, got_ea;
      logic [1:0]  ecyc;
      logic        ai;
      int          cyc, nrd, nwr, both, rd_bad;
      v = VEC[i];
      {op, ind, pg, off, ia, pre, ecyc} = v;
      fa      = ref_formed(pg, off, ia);
      ai      = ref_ai(ind, fa);
      exp_ea  = !ind ? fa : (ai ? pre + 12'd1 : pre);
      exp_mem = ai ? pre + 12'd1 : pre;
      preload(fa, pre);
      @(negedge clk);
      start_i = 1'b1; instr_i = {op, ind, pg, off}; iaddr_i = ia;
      #1;
      cyc = 0; nrd = 0; nwr = 0; both = 0; rd_bad = 0;
      while (!done_o && cyc < 10) begin
        @(negedge clk);
        start_i = 1'b0;
        #1;
        cyc++;
        if (mem_rd_o) begin nrd++; if (mem_addr_o != fa || cyc != 1) rd_bad++; end
        if (mem_wr_o) nwr++;
        if (mem_rd_o && mem_wr_o) both++;
      end
      got_ea = ea_o;
      if (cyc == 0) chk(!mem_rd_o && !mem_wr_o, "R3 no strobe on direct", {mem_rd_o, mem_wr_o}, 0);
      chk(done_o, "R4 done reached", done_o, 1);
      chk(cyc == int'(ecyc), ind ? (ai ? "R5 cycles" : "R4 cycles") : "R3 cycles", cyc, ecyc);
      chk(got_ea == exp_ea, !ind ? (pg ? "R2 ea" : "R1 ea") : (ai ? "R5 ea" : "R4 ea"), got_ea, exp_ea);
      chk(nrd == (ind ? 1 : 0) && rd_bad == 0, "R4 single read at formed address", nrd, ind);
      chk(nwr == (ai ? 1 : 0), "R7 write only for window pointer", nwr, ai);
      chk(both == 0, "R10 strobes exclusive", both, 0);
      @(negedge clk);
      start_i = 1'b0;
      #1;
      chk(mem[fa] == exp_mem, (pre == 12'o7777) ? "R6 wrap stored" : "R7 memory contents", mem[fa], exp_mem);
    end

    // R8: start during a busy reference is ignored
    preload(12'o0050, 12'o1357);
    @(negedge clk);
    start_i = 1'b1; instr_i = {3'o1, 1'b1, 1'b0, 7'o050}; iaddr_i = 12'o0;
    @(negedge clk);
    instr_i = {3'o1, 1'b0, 1'b0, 7'o045};
    #1;
    chk(!done_o && mem_rd_o, "R8 busy start ignored", {done_o, mem_rd_o}, 1);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(done_o && ea_o == 12'o1357, "R8 result kept", ea_o, 12'o1357);
    @(negedge clk);
    #1;
    chk(!done_o && !mem_rd_o && !mem_wr_o, "R8 idle after", {done_o, mem_rd_o, mem_wr_o}, 0);

    // R9: reset in the middle of an auto-increment reference
    preload(12'o0011, 12'o0123);
    @(negedge clk);
    start_i = 1'b1; instr_i = {3'o0, 1'b1, 1'b0, 7'o011}; iaddr_i = 12'o0;
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!mem_rd_o && !mem_wr_o && !done_o, "R9 reset aborts", {mem_rd_o, mem_wr_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(mem[12'o0011] == 12'o0123 && !done_o, "R9 no write after abort", mem[12'o0011], 12'o0123);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule